// File: doc/BRIEF.md
# Console keyboard input controller

This block sits between an operator keyboard and a character channel. Keys arrive as 7-bit ASCII codes with a valid/ready handshake. While a transfer is open, printable keys are folded into a 6-bit character set and handed, one at a time, to a channel port that can answer with an end-of-record mark. Each delivered character is also echoed as ASCII toward a printer. Unusable keys produce a bell pulse instead.

A CPU controls the block through a small register port. A command write opens or closes a transfer. A status read returns a 14-bit word and then clears it, keeping only the busy bit. A done flag goes to the interrupt logic whenever the block has something to report. Several keys are handled as special keys rather than as characters: line end, attention, cancel, and an escape prefix that selects one of five function keys. Each of them sets its own status bit. When a transfer is open, the line-end, attention and cancel keys also close it.

Top module: `conkey_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the status word, the done flag, the function prefix and the channel holding register, and leaves key_ready high.
- R2: A command write with cmd_bits[0] set opens a transfer (status bit 5 busy set, bit 0 end cleared). With cmd_bits[1] set it closes the transfer: end is set, busy is cleared and done rises.
- R3: stat_data shows the status word: bit 0 end, 5 busy, 6 attention, 7 cancel, 8 line accepted, 9 to 13 function keys 1 to 5. A stat_rd pulse leaves only bit 5 in the next cycle and clears done.
- R4: While busy, an accepted key with code 040 or above is converted as follows and appears on ch_data with ch_valid high one cycle later. Codes of 0140 and above first lose 040. Then codes of 0100 and above lose 040. Failing that, codes of 060 and above lose 060. Failing that, the code loses 020.
- R5: Each delivered character is echoed in the same cycle on echo_char with a one-cycle echo_valid. The echo value comes from ch_data[5:4]: 00 gives 060, 01 gives 040, 10 gives 0100 and 11 gives 0120, each ORed with ch_data[3:0].
- R6: While busy, a non-special key below 040 is not delivered and gives a one-cycle bell pulse.
- R7: While not busy, a plain key gives a bell pulse and nothing is delivered.
- R8: While busy, CR (015) or LF (012) sets bit 8 and bit 0, clears busy and raises done. While not busy, these keys only ring the bell.
- R9: Control-X (030) sets bit 6. Control-C (003) or control-U (025) sets bit 7. Each raises done. If busy, each also sets end and clears busy.
- R10: ESC (033) arms a function prefix. The next key, if it is '1' to '5', sets bit 9 plus (key minus '1') and raises done. Any other key rings the bell. Either way the prefix is cleared.
- R11: ch_valid and ch_data hold until ch_ready is high at a clock edge. key_ready is low while a character is pending, and no key is taken in that time.
- R12: A channel acceptance with ch_eor high clears busy, sets end and raises done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | Keyboard code present |
| key_code | input | 7 | ASCII key code |
| key_ready | output | 1 | Block can take a key this cycle |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 2 | Bit 0 open transfer, bit 1 close transfer |
| stat_rd | input | 1 | Status read strobe (clears after read) |
| stat_data | output | 14 | Status word |
| done | output | 1 | Attention flag toward the interrupt register |
| ch_valid | output | 1 | Character pending for the channel |
| ch_data | output | 6 | Converted 6-bit character |
| ch_ready | input | 1 | Channel takes the pending character |
| ch_eor | input | 1 | End of record, qualified by ch_ready |
| echo_valid | output | 1 | Echo character strobe |
| echo_char | output | 7 | ASCII echo toward the printer |
| bell | output | 1 | One-cycle bell request |

## Verification
Every result here is due exactly one clock edge after the stimulus that causes it. This covers the status bits and done after a key, a command, a read or an end-of-record, the pending character and its echo, and the bell pulse. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples on the next falling edge. One-cycle pulses such as echo_valid and bell are therefore seen in the only cycle they exist. For the hold behaviour, the bench keeps ch_ready low for an extra cycle while a second key is offered, and confirms that ch_data and key_ready have not moved.

// File: rtl/conkey_pkg.sv
package conkey_pkg;

    localparam int KEY_W  = 7;
    localparam int CHAR_W = 6;
    localparam int FKEY_N = 5;
    localparam int STAT_W = 9 + FKEY_N;

    // status bit positions (decoded by software)
    localparam int ST_END    = 0;
    localparam int ST_BUSY   = 5;
    localparam int ST_ATTN   = 6;
    localparam int ST_CANCEL = 7;
    localparam int ST_ACCEPT = 8;
    localparam int ST_F1     = 9;

    localparam logic [KEY_W-1:0] K_LF   = 7'o012;
    localparam logic [KEY_W-1:0] K_CR   = 7'o015;
    localparam logic [KEY_W-1:0] K_CTLC = 7'o003;
    localparam logic [KEY_W-1:0] K_CTLU = 7'o025;
    localparam logic [KEY_W-1:0] K_CTLX = 7'o030;
    localparam logic [KEY_W-1:0] K_ESC  = 7'o033;
    localparam logic [KEY_W-1:0] K_ONE  = 7'o061;

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic [2:0] {
        KC_PLAIN,
        KC_EOL,
        KC_PREFIX,
        KC_ATTN,
        KC_CANCEL
    } key_class_t;

    typedef struct packed {
        logic              arm_fn;
        logic              drop_fn;
        logic [FKEY_N-1:0] fkey;
        logic              accept;
        logic              attn;
        logic              cancel;
        logic              finish;
        logic              notify;
    } stat_evt_t;

    typedef struct packed {
        stat_evt_t         evt;
        logic              deliver;
        logic              ring;
        logic [CHAR_W-1:0] chr;
    } key_act_t;

    function automatic key_class_t classify(input logic [KEY_W-1:0] k);
        key_class_t c;
        case (k)
            K_CR, K_LF:     c = KC_EOL;
            K_ESC:          c = KC_PREFIX;
            K_CTLX:         c = KC_ATTN;
            K_CTLC, K_CTLU: c = KC_CANCEL;
            default:        c = KC_PLAIN;
        endcase
        return c;
    endfunction

    // returns {reject, character}
    function automatic logic [CHAR_W:0] fold_key(input logic [KEY_W-1:0] k);
        logic [KEY_W-1:0] c;
        logic             rej;
        c   = k;
        rej = 1'b0;
        if (c >= 7'o140) c = c - 7'o040;
        if (c >= 7'o100)      c = c - 7'o040;
        else if (c >= 7'o060) c = c - 7'o060;
        else if (c >= 7'o040) c = c - 7'o020;
        else                  rej = 1'b1;
        return {rej, c[CHAR_W-1:0]};
    endfunction

    function automatic logic [KEY_W-1:0] unfold_char(input logic [CHAR_W-1:0] ch);
        logic [KEY_W-1:0] base;
        case (ch[5:4])
            2'b00:   base = 7'o060;
            2'b01:   base = 7'o040;
            2'b10:   base = 7'o100;
            default: base = 7'o120;
        endcase
        return base | {3'b000, ch[3:0]};
    endfunction

endpackage

// File: rtl/conkey_decode.sv
module conkey_decode
    import conkey_pkg::*;
(
    input  logic [KEY_W-1:0] key_code,
    input  logic             busy,
    input  logic             fn_armed,
    output key_act_t         act
);

    logic [FKEY_N-1:0] fhit;
    logic [CHAR_W:0]   folded;
    key_class_t        cls;

    for (genvar g = 0; g < FKEY_N; g++) begin : g_fkey
        assign fhit[g] = (key_code == K_ONE + KEY_W'(g));
    end

    assign folded = fold_key(key_code);
    assign cls    = classify(key_code);

    always_comb begin
        act     = '0;
        act.chr = folded[CHAR_W-1:0];
        if (fn_armed) begin
            act.evt.drop_fn = 1'b1;
            if (|fhit) begin
                act.evt.fkey   = fhit;
                act.evt.notify = 1'b1;
            end else begin
                act.ring = 1'b1;
            end
        end else begin
            case (cls)
                KC_PREFIX: act.evt.arm_fn = 1'b1;
                KC_ATTN: begin
                    act.evt.attn    = 1'b1;
                    act.evt.notify  = 1'b1;
                    act.evt.finish  = busy;
                end
                KC_CANCEL: begin
                    act.evt.cancel  = 1'b1;
                    act.evt.notify  = 1'b1;
                    act.evt.finish  = busy;
                end
                KC_EOL: begin
                    if (busy) begin
                        act.evt.accept = 1'b1;
                        act.evt.finish = 1'b1;
                        act.evt.notify = 1'b1;
                    end else begin
                        act.ring = 1'b1;
                    end
                end
                default: begin
                    if (busy && !folded[CHAR_W]) act.deliver = 1'b1;
                    else                         act.ring    = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/conkey_status.sv
module conkey_status
    import conkey_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_wr,
    input  logic [1:0] cmd_bits,
    input  logic      stat_rd,
    input  logic      key_fire,
    input  stat_evt_t evt,
    input  logic      eor_fire,
    output stat_t     stat_q,
    output logic      done_q,
    output logic      fn_armed
);

    localparam stat_t BUSY_ONLY = stat_t'(1) << ST_BUSY;

    stat_t s_n;
    logic  done_n;
    logic  fn_n;
    logic  do_start;
    logic  do_stop;

    assign do_start = cmd_wr & cmd_bits[0];
    assign do_stop  = cmd_wr & cmd_bits[1];

    always_comb begin
        s_n    = stat_q;
        done_n = done_q;
        fn_n   = fn_armed;
        if (stat_rd) begin
            s_n    = stat_q & BUSY_ONLY;
            done_n = 1'b0;
        end
        if (do_start) begin
            s_n[ST_BUSY] = 1'b1;
            s_n[ST_END]  = 1'b0;
        end
        if (do_stop) begin
            s_n[ST_END]  = 1'b1;
            s_n[ST_BUSY] = 1'b0;
            done_n       = 1'b1;
        end
        if (key_fire) begin
            s_n[ST_F1 +: FKEY_N] = s_n[ST_F1 +: FKEY_N] | evt.fkey;
            if (evt.accept) s_n[ST_ACCEPT] = 1'b1;
            if (evt.attn)   s_n[ST_ATTN]   = 1'b1;
            if (evt.cancel) s_n[ST_CANCEL] = 1'b1;
            if (evt.finish) begin
                s_n[ST_END]  = 1'b1;
                s_n[ST_BUSY] = 1'b0;
            end
            if (evt.notify) done_n = 1'b1;
            if (evt.drop_fn)     fn_n = 1'b0;
            else if (evt.arm_fn) fn_n = 1'b1;
        end
        if (eor_fire) begin
            s_n[ST_END]  = 1'b1;
            s_n[ST_BUSY] = 1'b0;
            done_n       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            done_q   <= 1'b0;
            fn_armed <= 1'b0;
        end else begin
            stat_q   <= s_n;
            done_q   <= done_n;
            fn_armed <= fn_n;
        end
    end

    // R3: a lone read leaves only the busy bit and drops done
    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !cmd_wr && !key_fire && !eor_fire)
        |=> ((stat_q & ~BUSY_ONLY) == '0) && !done_q
            && (stat_q[ST_BUSY] == $past(stat_q[ST_BUSY])));

    // R2: open command
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_bits == 2'b01 && !key_fire && !eor_fire)
        |=> stat_q[ST_BUSY] && !stat_q[ST_END]);

    // R2: close command
    p_stop_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_bits[1])
        |=> stat_q[ST_END] && !stat_q[ST_BUSY] && done_q);

    // R12: end of record closes the transfer
    p_eor_closes_r12: assert property (@(posedge clk) disable iff (rst)
        (eor_fire && !(cmd_wr && cmd_bits[0]))
        |=> stat_q[ST_END] && !stat_q[ST_BUSY] && done_q);

    // R10: the prefix lasts for exactly one following key
    p_prefix_once_r10: assert property (@(posedge clk) disable iff (rst)
        (key_fire && fn_armed) |=> !fn_armed);

endmodule

// File: rtl/conkey_chan.sv
module conkey_chan
    import conkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              deliver,
    input  logic              ring,
    input  logic [CHAR_W-1:0] chr,
    input  logic              ch_ready,
    input  logic              ch_eor,
    output logic              ch_valid,
    output logic [CHAR_W-1:0] ch_data,
    output logic              echo_valid,
    output logic [KEY_W-1:0]  echo_char,
    output logic              bell,
    output logic              eor_fire
);

    assign eor_fire = ch_valid & ch_ready & ch_eor;

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_valid   <= 1'b0;
            ch_data    <= '0;
            echo_valid <= 1'b0;
            echo_char  <= '0;
            bell       <= 1'b0;
        end else begin
            if (ch_valid && ch_ready) ch_valid <= 1'b0;
            if (deliver) begin
                ch_valid  <= 1'b1;
                ch_data   <= chr;
                echo_char <= unfold_char(chr);
            end
            echo_valid <= deliver;
            bell       <= ring;
        end
    end

    // R11: pending character is held until taken
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (ch_valid && !ch_ready) |=> ch_valid && $stable(ch_data));

    // R11: a new character never lands on a pending one
    p_no_overrun_r11: assert property (@(posedge clk) disable iff (rst)
        deliver |-> !ch_valid);

    // R5: echo is always a printable code
    p_echo_range_r5: assert property (@(posedge clk) disable iff (rst)
        echo_valid |-> (echo_char >= 7'o040) && (echo_char <= 7'o137));

    // R6: bell and delivery never coincide
    p_bell_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(bell && echo_valid));

endmodule

// File: rtl/conkey_ctrl.sv
module conkey_ctrl
    import conkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key_code,
    output logic              key_ready,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_bits,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_data,
    output logic              done,
    output logic              ch_valid,
    output logic [CHAR_W-1:0] ch_data,
    input  logic              ch_ready,
    input  logic              ch_eor,
    output logic              echo_valid,
    output logic [KEY_W-1:0]  echo_char,
    output logic              bell
);

    key_act_t act;
    key_act_t act_g;
    stat_t    stat_q;
    logic     fn_armed;
    logic     key_fire;
    logic     eor_fire;

    assign key_ready = ~ch_valid;
    assign key_fire  = key_valid & key_ready;
    assign act_g     = key_fire ? act : '0;
    assign stat_data = stat_q;

    conkey_decode u_decode (
        .key_code (key_code),
        .busy     (stat_q[ST_BUSY]),
        .fn_armed (fn_armed),
        .act      (act)
    );

    conkey_status u_status (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_bits (cmd_bits),
        .stat_rd  (stat_rd),
        .key_fire (key_fire),
        .evt      (act_g.evt),
        .eor_fire (eor_fire),
        .stat_q   (stat_q),
        .done_q   (done),
        .fn_armed (fn_armed)
    );

    conkey_chan u_chan (
        .clk        (clk),
        .rst        (rst),
        .deliver    (act_g.deliver),
        .ring       (act_g.ring),
        .chr        (act_g.chr),
        .ch_ready   (ch_ready),
        .ch_eor     (ch_eor),
        .ch_valid   (ch_valid),
        .ch_data    (ch_data),
        .echo_valid (echo_valid),
        .echo_char  (echo_char),
        .bell       (bell),
        .eor_fire   (eor_fire)
    );

    // R11: no key is taken while a character is pending
    p_key_blocked_r11: assert property (@(posedge clk) disable iff (rst)
        (key_valid && ch_valid && !ch_ready) |=> $stable(ch_data) && !echo_valid);

endmodule

// File: tb/test_conkey_ctrl.sv
module test_conkey_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic [6:0] key_code = '0;
    logic       key_ready;
    logic       cmd_wr = 1'b0;
    logic [1:0] cmd_bits = '0;
    logic       stat_rd = 1'b0;
    logic [13:0] stat_data;
    logic       done;
    logic       ch_valid;
    logic [5:0] ch_data;
    logic       ch_ready = 1'b0;
    logic       ch_eor = 1'b0;
    logic       echo_valid;
    logic [6:0] echo_char;
    logic       bell;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    conkey_ctrl i_conkey_ctrl (.*);

    // {key, deliverable, char6, echo}
    localparam int NV = 16;
    localparam logic [20:0] VEC [NV] = '{
        {7'o101, 1'b1, 6'o41, 7'o101},
        {7'o141, 1'b1, 6'o41, 7'o101},
        {7'o060, 1'b1, 6'o00, 7'o060},
        {7'o071, 1'b1, 6'o11, 7'o071},
        {7'o040, 1'b1, 6'o20, 7'o040},
        {7'o041, 1'b1, 6'o21, 7'o041},
        {7'o057, 1'b1, 6'o37, 7'o057},
        {7'o100, 1'b1, 6'o40, 7'o100},
        {7'o137, 1'b1, 6'o77, 7'o137},
        {7'o177, 1'b1, 6'o77, 7'o137},
        {7'o172, 1'b1, 6'o72, 7'o132},
        {7'o173, 1'b1, 6'o73, 7'o133},
        {7'o140, 1'b1, 6'o40, 7'o100},
        {7'o001, 1'b0, 6'o00, 7'o000},
        {7'o002, 1'b0, 6'o00, 7'o000},
        {7'o037, 1'b0, 6'o00, 7'o000}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0o expected %0o", req, act, exp);
        end
    endtask

    task automatic press(input logic [6:0] k);
        key_valid = 1'b1; key_code = k;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic command(input logic [1:0] b);
        cmd_wr = 1'b1; cmd_bits = b;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_bits = '0;
    endtask

    task automatic read_stat(input string req, input int exp);
        chk(req, stat_data, exp);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic drain(input logic eor);
        ch_ready = 1'b1; ch_eor = eor;
        @(negedge clk);
        ch_ready = 1'b0; ch_eor = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 stat", stat_data, 0);
        chk("R1 done", done, 0);
        chk("R1 ch_valid", ch_valid, 0);
        chk("R1 key_ready", key_ready, 1);
        rst = 1'b0;
        @(negedge clk);

        // R2 open
        command(2'b01);
        chk("R2 open stat", stat_data, 14'o40);
        chk("R2 open done", done, 0);

        // R4 R5 R6 vector walk
        for (int i = 0; i < NV; i++) begin
            press(VEC[i][20:14]);
            if (VEC[i][13]) begin
                chk("R4 ch_valid", ch_valid, 1);
                chk("R4 ch_data", ch_data, VEC[i][12:7]);
                chk("R5 echo_valid", echo_valid, 1);
                chk("R5 echo_char", echo_char, VEC[i][6:0]);
                chk("R4 no bell", bell, 0);
                if (i == 0) begin
                    // R11 hold while pending, second key refused
                    chk("R11 key_ready low", key_ready, 0);
                    key_valid = 1'b1; key_code = 7'o102;
                    @(negedge clk);
                    key_valid = 1'b0;
                    chk("R11 held valid", ch_valid, 1);
                    chk("R11 held data", ch_data, VEC[i][12:7]);
                    chk("R11 no echo", echo_valid, 0);
                end
                drain(1'b0);
                chk("R11 taken", ch_valid, 0);
                chk("R4 still busy", stat_data, 14'o40);
            end else begin
                chk("R6 bell", bell, 1);
                chk("R6 no delivery", ch_valid, 0);
                chk("R6 no echo", echo_valid, 0);
            end
        end

        // R12 end of record
        press(7'o101);
        drain(1'b1);
        chk("R12 stat", stat_data, 14'o1);
        chk("R12 done", done, 1);

        // R3 read returns word, then clears
        read_stat("R3 read value", 14'o1);
        chk("R3 cleared", stat_data, 0);
        chk("R3 done cleared", done, 0);

        // R7 idle plain key
        press(7'o101);
        chk("R7 bell", bell, 1);
        chk("R7 no delivery", ch_valid, 0);
        // R8 idle CR
        press(7'o015);
        chk("R8 idle bell", bell, 1);
        chk("R8 idle stat", stat_data, 0);

        // R8 busy CR / LF
        command(2'b01);
        press(7'o015);
        chk("R8 accept stat", stat_data, 14'o401);
        chk("R8 done", done, 1);
        read_stat("R8 read", 14'o401);
        command(2'b01);
        press(7'o012);
        chk("R8 LF stat", stat_data, 14'o401);
        read_stat("R8 LF read", 14'o401);

        // R9 attention idle, cancel busy
        press(7'o030);
        chk("R9 attn stat", stat_data, 14'o100);
        chk("R9 attn done", done, 1);
        read_stat("R9 attn read", 14'o100);
        command(2'b01);
        press(7'o003);
        chk("R9 ctl-C stat", stat_data, 14'o201);
        chk("R9 ctl-C done", done, 1);
        read_stat("R9 ctl-C read", 14'o201);
        command(2'b01);
        press(7'o025);
        chk("R9 ctl-U stat", stat_data, 14'o201);
        read_stat("R9 ctl-U read", 14'o201);
        command(2'b01);
        press(7'o030);
        chk("R9 attn busy stat", stat_data, 14'o101);
        read_stat("R9 attn busy read", 14'o101);

        // R10 function prefix
        press(7'o033);
        chk("R10 armed no done", done, 0);
        press(7'o063);
        chk("R10 F3 stat", stat_data, 14'o4000);
        chk("R10 F3 done", done, 1);
        read_stat("R10 F3 read", 14'o4000);
        press(7'o033);
        press(7'o170);
        chk("R10 bad key bell", bell, 1);
        chk("R10 bad key stat", stat_data, 0);
        press(7'o062);
        chk("R10 prefix cleared bell", bell, 1);
        chk("R10 prefix cleared stat", stat_data, 0);
        press(7'o033);
        press(7'o065);
        chk("R10 F5 stat", stat_data, 14'o20000);
        read_stat("R10 F5 read", 14'o20000);

        // R3 read while busy keeps busy; R2 close
        command(2'b01);
        read_stat("R3 busy read", 14'o40);
        chk("R3 busy kept", stat_data, 14'o40);
        command(2'b10);
        chk("R2 close stat", stat_data, 14'o1);
        chk("R2 close done", done, 1);

        finish_run();
    end

endmodule